// File: doc/BRIEF.md
# SCSI Initiator Host Register Interface

This block is the processor-facing register file and command decoder of a SCSI initiator controller. A host reaches it through a 4-bit register address with separate write and read strobes and 8-bit data. It holds the own-ID setting, the control register that switches the controller on and off, the command register, the interrupt sense bits, the phase control value and a write-side shadow of the temporary register. The phase sequencer that actually moves the bus signals sits beside it.

A write to the command register is decoded into single-cycle strobes for that sequencer: bus release (disconnect), ACK/REQ set and clear, and a selection strobe carrying the resolved target number. The block also keeps the attention (ATN) and bus reset flags and the transfer-in-progress flag. The sequencer supplies the current phase-sense byte, the byte received from the target, a bus-free indication, and the target's acknowledgement of selection.

Top module: `scsi_hri`

## Requirements
- R1: After reset, address 0 reads 0x80 (own ID 7), address 1 reads 0x80, addresses 2, 4 and 8 read 0x00, and the controller is disabled with ATN and bus reset low.
- R2: A write to address 0 keeps only wr_data[2:0] as the own ID; address 0 then reads back the one-hot value 1 << ID.
- R3: A write to address 1 enables the controller exactly when wr_data[7:5] is 000. Going from enabled to disabled clears the command, interrupt sense, phase control and temp shadow registers, drops ATN and transfer-in-progress, and pulses disc_stb.
- R4: While disabled, writes to address 2 have no effect: the register keeps its value, no strobe fires and ATN does not change.
- R5: Command codes (wr_data[7:5] at address 2) 011 and 010 set and clear ATN; address 5 reads psns_in with bit 5 replaced by ATN OR'ed in.
- R6: Command bit 4 raises bus reset only when the previous command value had bit 4 clear and the control register equals 0x00; this sets interrupt bit 0 and disconnects. A command write with bit 4 clear drops bus reset.
- R7: Writing address 4 clears every interrupt bit written as 1; bit 0 stays set while bus reset is active.
- R8: Select (001) succeeds when the bus is free, the temp shadow holds the own-ID bit and at least one other bit, and tgt_ack is high; sel_tgt is the highest set bit of the shadow excluding the own bit, sel_go pulses, sel_msgout shows ATN, and interrupt bit 4 (command complete) sets.
- R9: A select with bus reset active sets interrupt bit 2 (timeout) without a disconnect; with phase-control bit 0 set or the R8 conditions failing it sets bit 2 and disconnects.
- R10: Transfer (100) sets xfer_active when psns_in[2:0] equals phase control bits [2:0] and psns_in bit 7 (REQ) or bit 3 (BSY) is high; otherwise it sets interrupt bit 3 (service required).
- R11: Code 111 pulses ack_set_stb with ack_data taken from rx_temp when psns_in bit 0 (input direction) is 1 and from the temp shadow otherwise; code 110 pulses ack_clr_stb.
- R12: A disconnect (code 000, failed selection, bus reset) pulses disc_stb, clears ATN and xfer_active, and sets interrupt bit 5 when bus_free is low.
- R13: Register writes become visible in the cycle after the write strobe; every strobe output is high for one cycle only.
- R14: Address 11 reads rx_temp, address 15 reads 0xFF, addresses 3, 6, 7, 9, 10, 12, 13, 14 read 0x00 and ignore writes; rd_data is 0x00 when rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data (combinational) |
| psns_in | input | 8 | Phase sense byte from the sequencer (bit 7 REQ, bit 3 BSY, bits 2:0 phase) |
| rx_temp | input | 8 | Byte most recently received from the target |
| bus_free | input | 1 | Bus is in the free phase |
| tgt_ack | input | 1 | Target acknowledges selection of sel_tgt |
| ctl_enabled | output | 1 | Controller enabled |
| atn | output | 1 | Attention flag |
| bus_rst | output | 1 | Bus reset flag |
| xfer_active | output | 1 | Transfer in progress |
| sel_tgt | output | 3 | Resolved target number |
| sel_msgout | output | 1 | Selection enters Message Out (ATN was set) |
| sel_go | output | 1 | Selection succeeded strobe |
| ack_set_stb | output | 1 | Set ACK/REQ strobe |
| ack_clr_stb | output | 1 | Clear ACK/REQ strobe |
| ack_data | output | 8 | Byte supplied with the set ACK/REQ strobe |
| disc_stb | output | 1 | Disconnect strobe |

## Verification
The properties assume the host inputs are quiet during reset, so that the first cycle after reset sees no write that was sampled while reset was high, and that bus_free and tgt_ack are valid in the cycle of a select write. The bench drives all inputs at the falling edge, holds wr_en and rd_en low through reset, and changes bus_free, tgt_ack and psns_in only between register accesses, so each command write sees a stable sequencer view.

// File: rtl/scsi_hri_pkg.sv
package scsi_hri_pkg;

    localparam int DATA_W = 8;
    localparam int ID_W   = 3;
    localparam int ADDR_W = 4;
    localparam int N_ID   = 1 << ID_W;

    // register addresses handled here
    localparam logic [ADDR_W-1:0] A_OWNID = 4'd0;
    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd1;
    localparam logic [ADDR_W-1:0] A_CMD   = 4'd2;
    localparam logic [ADDR_W-1:0] A_INT   = 4'd4;
    localparam logic [ADDR_W-1:0] A_PHASE = 4'd5;
    localparam logic [ADDR_W-1:0] A_PCTL  = 4'd8;
    localparam logic [ADDR_W-1:0] A_TEMP  = 4'd11;
    localparam logic [ADDR_W-1:0] A_OPEN  = 4'd15;

    // interrupt sense bit positions
    localparam int INT_RST   = 0;
    localparam int INT_TMO   = 2;
    localparam int INT_SVC   = 3;
    localparam int INT_DONE  = 4;
    localparam int INT_DISC  = 5;

    localparam int PS_REQ = 7;
    localparam int PS_BSY = 3;
    localparam int PS_ATN = 5;
    localparam int PS_IO  = 0;

    typedef enum logic [2:0] {
        OP_RELEASE = 3'd0,
        OP_SELECT  = 3'd1,
        OP_ATN_CLR = 3'd2,
        OP_ATN_SET = 3'd3,
        OP_XFER    = 3'd4,
        OP_PAUSE   = 3'd5,
        OP_ACK_CLR = 3'd6,
        OP_ACK_SET = 3'd7
    } cmd_op_e;

    typedef struct packed {
        logic    valid;
        cmd_op_e op;
        logic    rst_req;
    } cmd_t;

    typedef struct packed {
        logic own;
        logic ctrl;
        logic ints;
        logic pctl;
        logic temp;
    } wsel_t;

    typedef struct packed {
        logic sel;
        logic ack_set;
        logic ack_clr;
        logic disc;
    } strobe_t;

    function automatic logic [DATA_W-1:0] id_mask(input logic [ID_W-1:0] id);
        return DATA_W'(1) << id;
    endfunction

endpackage

// File: rtl/scsi_hri_wdec.sv
module scsi_hri_wdec
    import scsi_hri_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:4]        cmd_bits,
    input  logic              enabled,
    output wsel_t             wsel,
    output cmd_t              cmd
);
    always_comb begin
        wsel      = '0;
        wsel.own  = wr_en && (addr == A_OWNID);
        wsel.ctrl = wr_en && (addr == A_CTRL);
        wsel.ints = wr_en && (addr == A_INT);
        wsel.pctl = wr_en && (addr == A_PCTL);
        wsel.temp = wr_en && (addr == A_TEMP);

        cmd.valid   = wr_en && (addr == A_CMD) && enabled;
        cmd.op      = cmd_op_e'(cmd_bits[7:5]);
        cmd.rst_req = cmd_bits[4];
    end
endmodule

// File: rtl/scsi_hri_tgt_sel.sv
module scsi_hri_tgt_sel
    import scsi_hri_pkg::*;
#(
    parameter int IDW = ID_W,
    localparam int N  = 1 << IDW
) (
    input  logic [N-1:0]   cand,
    input  logic [IDW-1:0] own_id,
    output logic [IDW-1:0] tgt_id,
    output logic           has_own,
    output logic           has_other
);
    logic [N-1:0] own_mask;
    logic [N-1:0] others;

    for (genvar g = 0; g < N; g++) begin : g_mask
        assign own_mask[g] = (own_id == IDW'(g));
    end

    assign others    = cand & ~own_mask;
    assign has_own   = |(cand & own_mask);
    assign has_other = |others;

    // higher index overrides lower: highest remaining bit wins
    always_comb begin
        tgt_id = '0;
        for (int i = 0; i < N; i++) begin
            if (others[i]) tgt_id = IDW'(i);
        end
    end
endmodule

// File: rtl/scsi_hri_int_reg.sv
module scsi_hri_int_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_m,
    input  logic [W-1:0] clr_m,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr_m) | set_m;
    end
endmodule

// File: rtl/scsi_hri.sv
module scsi_hri
    import scsi_hri_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] psns_in,
    input  logic [DATA_W-1:0] rx_temp,
    input  logic              bus_free,
    input  logic              tgt_ack,
    output logic              ctl_enabled,
    output logic              atn,
    output logic              bus_rst,
    output logic              xfer_active,
    output logic [ID_W-1:0]   sel_tgt,
    output logic              sel_msgout,
    output logic              sel_go,
    output logic              ack_set_stb,
    output logic              ack_clr_stb,
    output logic [DATA_W-1:0] ack_data,
    output logic              disc_stb
);
    localparam logic [ID_W-1:0]   RST_ID   = ID_W'(N_ID - 1);
    localparam logic [DATA_W-1:0] RST_CTRL = DATA_W'(1) << (DATA_W - 1);

    // state
    logic [ID_W-1:0]   own_q,  own_n;
    logic [DATA_W-1:0] sctl_q, sctl_n;
    logic              en_q,   en_n;
    logic [DATA_W-1:0] scmd_q, scmd_n;
    logic [DATA_W-1:0] pctl_q, pctl_n;
    logic [DATA_W-1:0] temp_q, temp_n;
    logic              atn_q,  atn_n;
    logic              brst_q, brst_n;
    logic              xfer_q, xfer_n;
    logic              msgo_q, msgo_n;
    logic [DATA_W-1:0] ackd_q, ackd_n;
    strobe_t           stb_q,  stb_n;

    logic [DATA_W-1:0] int_q, int_set, int_clr;

    wsel_t             ws;
    cmd_t              cmd;
    logic [ID_W-1:0]   tgt_id;
    logic              has_own, has_other;
    logic              phase_ok;
    logic              sel_ok;

    scsi_hri_wdec u_wdec (
        .wr_en    (wr_en),
        .addr     (reg_addr),
        .cmd_bits (wr_data[7:4]),
        .enabled  (en_q),
        .wsel     (ws),
        .cmd      (cmd)
    );

    scsi_hri_tgt_sel #(.IDW(ID_W)) u_tsel (
        .cand      (temp_q),
        .own_id    (own_q),
        .tgt_id    (tgt_id),
        .has_own   (has_own),
        .has_other (has_other)
    );

    scsi_hri_int_reg #(.W(DATA_W)) u_ints (
        .clk   (clk),
        .rst   (rst),
        .set_m (int_set),
        .clr_m (int_clr),
        .q     (int_q)
    );

    assign phase_ok = (psns_in[2:0] == pctl_q[2:0]) &&
                      (psns_in[PS_REQ] || psns_in[PS_BSY]);
    assign sel_ok   = bus_free && has_own && has_other && tgt_ack;

    always_comb begin
        own_n   = own_q;
        sctl_n  = sctl_q;
        en_n    = en_q;
        scmd_n  = scmd_q;
        pctl_n  = pctl_q;
        temp_n  = temp_q;
        atn_n   = atn_q;
        brst_n  = brst_q;
        xfer_n  = xfer_q;
        msgo_n  = msgo_q;
        ackd_n  = ackd_q;
        stb_n   = '0;
        int_set = '0;
        int_clr = '0;

        if (ws.own)  own_n  = wr_data[ID_W-1:0];
        if (ws.pctl) pctl_n = wr_data;
        if (ws.temp) temp_n = wr_data;

        if (ws.ctrl) begin
            sctl_n = wr_data;
            en_n   = (wr_data[7:5] == 3'b000);
            if (en_q && !en_n) begin
                scmd_n     = '0;
                pctl_n     = '0;
                temp_n     = '0;
                int_clr    = '1;
                atn_n      = 1'b0;
                xfer_n     = 1'b0;
                stb_n.disc = 1'b1;
            end
        end

        if (ws.ints) begin
            int_clr          = wr_data;
            int_set[INT_RST] = brst_q;
        end

        if (cmd.valid) begin
            scmd_n = wr_data;
            if (cmd.rst_req) begin
                if (!scmd_q[4] && (sctl_q == '0)) begin
                    brst_n           = 1'b1;
                    int_set[INT_RST] = 1'b1;
                    atn_n            = 1'b0;
                    xfer_n           = 1'b0;
                    stb_n.disc       = 1'b1;
                    if (!bus_free) int_set[INT_DISC] = 1'b1;
                end
            end else begin
                brst_n = 1'b0;
            end

            unique case (cmd.op)
                OP_RELEASE: begin
                    atn_n      = 1'b0;
                    xfer_n     = 1'b0;
                    stb_n.disc = 1'b1;
                    if (!bus_free) int_set[INT_DISC] = 1'b1;
                end
                OP_SELECT: begin
                    if (brst_n) begin
                        int_set[INT_TMO] = 1'b1;
                    end else if (pctl_q[0] || !sel_ok) begin
                        int_set[INT_TMO] = 1'b1;
                        atn_n            = 1'b0;
                        xfer_n           = 1'b0;
                        stb_n.disc       = 1'b1;
                        if (!bus_free) int_set[INT_DISC] = 1'b1;
                    end else begin
                        int_set[INT_DONE] = 1'b1;
                        stb_n.sel         = 1'b1;
                        msgo_n            = atn_n;
                    end
                end
                OP_ATN_CLR: atn_n = 1'b0;
                OP_ATN_SET: atn_n = 1'b1;
                OP_XFER: begin
                    if (phase_ok) xfer_n = 1'b1;
                    else          int_set[INT_SVC] = 1'b1;
                end
                OP_PAUSE: ;
                OP_ACK_CLR: stb_n.ack_clr = 1'b1;
                OP_ACK_SET: begin
                    stb_n.ack_set = 1'b1;
                    ackd_n        = psns_in[PS_IO] ? rx_temp : temp_q;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q  <= RST_ID;
            sctl_q <= RST_CTRL;
            en_q   <= 1'b0;
            scmd_q <= '0;
            pctl_q <= '0;
            temp_q <= '0;
            atn_q  <= 1'b0;
            brst_q <= 1'b0;
            xfer_q <= 1'b0;
            msgo_q <= 1'b0;
            ackd_q <= '0;
            stb_q  <= '0;
        end else begin
            own_q  <= own_n;
            sctl_q <= sctl_n;
            en_q   <= en_n;
            scmd_q <= scmd_n;
            pctl_q <= pctl_n;
            temp_q <= temp_n;
            atn_q  <= atn_n;
            brst_q <= brst_n;
            xfer_q <= xfer_n;
            msgo_q <= msgo_n;
            ackd_q <= ackd_n;
            stb_q  <= stb_n;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (reg_addr)
                A_OWNID: rd_data = id_mask(own_q);
                A_CTRL:  rd_data = sctl_q;
                A_CMD:   rd_data = scmd_q;
                A_INT:   rd_data = int_q;
                A_PHASE: rd_data = psns_in | (DATA_W'(atn_q) << PS_ATN);
                A_PCTL:  rd_data = pctl_q;
                A_TEMP:  rd_data = rx_temp;
                A_OPEN:  rd_data = '1;
                default: rd_data = '0;
            endcase
        end
    end

    assign ctl_enabled = en_q;
    assign atn         = atn_q;
    assign bus_rst     = brst_q;
    assign xfer_active = xfer_q;
    assign sel_tgt     = tgt_id;
    assign sel_msgout  = msgo_q;
    assign sel_go      = stb_q.sel;
    assign ack_set_stb = stb_q.ack_set;
    assign ack_clr_stb = stb_q.ack_clr;
    assign ack_data    = ackd_q;
    assign disc_stb    = stb_q.disc;

endmodule

// File: rtl/scsi_hri_chk.sv
module scsi_hri_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] reg_addr,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       rd_en,
    input logic [7:0] rd_data,
    input logic       bus_free,
    input logic       tgt_ack,
    input logic       ctl_enabled,
    input logic       atn,
    input logic       bus_rst,
    input logic       sel_go,
    input logic       ack_set_stb,
    input logic       ack_clr_stb
);
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_go, ack_set_stb, ack_clr_stb})); // R13

    AST_ACK_FROM_CMD_WRITE: assert property (@(posedge clk) disable iff (rst)
        ack_set_stb |-> $past(wr_en && reg_addr == 4'd2 && wr_data[7:5] == 3'b111)); // R11

    AST_NO_CMD_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (ack_set_stb || ack_clr_stb || sel_go) |-> $past(ctl_enabled)); // R4

    AST_SEL_NEEDS_FREE_ACK: assert property (@(posedge clk) disable iff (rst)
        sel_go |-> $past(bus_free && tgt_ack)); // R8

    AST_ATN_AFTER_SET: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && reg_addr == 4'd2 && ctl_enabled && wr_data[7:5] == 3'b011) |-> atn); // R5

    AST_RST_BIT_HELD: assert property (@(posedge clk) disable iff (rst)
        (rd_en && reg_addr == 4'd4 && bus_rst) |-> rd_data[0]); // R7

    AST_OWNID_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        (rd_en && reg_addr == 4'd0) |-> ($countones(rd_data) == 1)); // R2
endmodule

bind scsi_hri scsi_hri_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_addr    (reg_addr),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .bus_free    (bus_free),
    .tgt_ack     (tgt_ack),
    .ctl_enabled (ctl_enabled),
    .atn         (atn),
    .bus_rst     (bus_rst),
    .sel_go      (sel_go),
    .ack_set_stb (ack_set_stb),
    .ack_clr_stb (ack_clr_stb)
);

// File: tb/scsi_hri_tb.sv
`timescale 1ns/1ps
module scsi_hri_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] reg_addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] psns_in = '0;
    logic [7:0] rx_temp = 8'hC3;
    logic       bus_free = 1'b1;
    logic       tgt_ack = 1'b1;
    logic       ctl_enabled, atn, bus_rst, xfer_active;
    logic [2:0] sel_tgt;
    logic       sel_msgout, sel_go, ack_set_stb, ack_clr_stb, disc_stb;
    logic [7:0] ack_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    scsi_hri u_dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .psns_in(psns_in), .rx_temp(rx_temp), .bus_free(bus_free),
        .tgt_ack(tgt_ack), .ctl_enabled(ctl_enabled), .atn(atn),
        .bus_rst(bus_rst), .xfer_active(xfer_active), .sel_tgt(sel_tgt),
        .sel_msgout(sel_msgout), .sel_go(sel_go), .ack_set_stb(ack_set_stb),
        .ack_clr_stb(ack_clr_stb), .ack_data(ack_data), .disc_stb(disc_stb)
    );

    typedef struct packed {
        logic [3:0] wa;
        logic [7:0] wd;
        logic [3:0] ra;
        logic [7:0] ex;
        logic [7:0] rq;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{4'd0,  8'h05, 4'd0,  8'h20, 8'd2},  // R2
        '{4'd0,  8'hFB, 4'd0,  8'h08, 8'd2},  // R2
        '{4'd1,  8'h00, 4'd1,  8'h00, 8'd3},  // R3
        '{4'd8,  8'h5A, 4'd8,  8'h5A, 8'd13}, // R13
        '{4'd11, 8'h3C, 4'd11, 8'hC3, 8'd14}, // R14
        '{4'd2,  8'h60, 4'd5,  8'h20, 8'd5},  // R5
        '{4'd2,  8'h40, 4'd5,  8'h00, 8'd5},  // R5
        '{4'd3,  8'h77, 4'd3,  8'h00, 8'd14}, // R14
        '{4'd4,  8'h00, 4'd15, 8'hFF, 8'd14}, // R14
        '{4'd2,  8'hA0, 4'd2,  8'hA0, 8'd13}  // R13
    };

    task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; rd_en = 1'b1;
        #1 v = rd_data;
        rd_en = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(4'd0, v); chk("R1 id", v, 8'h80);
        rd(4'd1, v); chk("R1 ctrl", v, 8'h80);
        rd(4'd2, v); chk("R1 cmd", v, 8'h00);
        rd(4'd4, v); chk("R1 ints", v, 8'h00);
        rd(4'd8, v); chk("R1 pctl", v, 8'h00);
        chk("R1 flags", {5'b0, ctl_enabled, atn, bus_rst}, 8'h00);
        rd_en = 1'b0; #1 chk("R14 idle read", rd_data, 8'h00);

        // R4 disabled: commands ignored
        wr(4'd2, 8'h60);
        chk("R4 atn", {7'b0, atn}, 8'h00);
        wr(4'd2, 8'hE0);
        chk("R4 strobe", {7'b0, ack_set_stb}, 8'h00);
        rd(4'd2, v); chk("R4 cmd reg", v, 8'h00);

        // table walk
        for (int i = 0; i < 10; i++) begin
            wr(VEC[i].wa, VEC[i].wd);
            rd(VEC[i].ra, v);
            chk($sformatf("R%0d vec%0d", VEC[i].rq, i), v, VEC[i].ex);
        end
        chk("R3 enabled", {7'b0, ctl_enabled}, 8'h01);

        // R6 bus reset
        wr(4'd8, 8'h00);
        wr(4'd2, 8'h10);
        chk("R6 rst flag", {7'b0, bus_rst}, 8'h01);
        chk("R6 disc", {7'b0, disc_stb}, 8'h01);
        rd(4'd4, v); chk("R6 int0", v, 8'h01);
        wr(4'd4, 8'hFF);
        rd(4'd4, v); chk("R7 held", v, 8'h01);
        wr(4'd2, 8'h30);
        chk("R9 no disc under rst", {7'b0, disc_stb}, 8'h00);
        rd(4'd4, v); chk("R9 timeout", v, 8'h05);
        wr(4'd2, 8'h00);
        chk("R6 drop", {7'b0, bus_rst}, 8'h00);
        wr(4'd4, 8'hFF);
        rd(4'd4, v); chk("R7 clear", v, 8'h00);

        // R8 selection success: own ID 3, shadow 0x3C -> target 5
        chk("R8 tgt", {5'b0, sel_tgt}, 8'h05);
        wr(4'd2, 8'h20);
        chk("R8 go", {6'b0, sel_go, sel_msgout}, 8'h02);
        rd(4'd4, v); chk("R8 done", v, 8'h10);
        chk("R13 pulse", {7'b0, sel_go}, 8'h00);
        wr(4'd2, 8'h60);
        wr(4'd2, 8'h20);
        chk("R8 msgout", {6'b0, sel_go, sel_msgout}, 8'h03);
        wr(4'd4, 8'hFF);

        // R9 selection failures
        tgt_ack = 1'b0;
        wr(4'd2, 8'h20);
        chk("R9 no ack", {6'b0, sel_go, disc_stb}, 8'h01);
        chk("R12 atn dropped", {7'b0, atn}, 8'h00);
        rd(4'd4, v); chk("R9 tmo", v, 8'h04);
        tgt_ack = 1'b1;
        wr(4'd11, 8'h30);
        wr(4'd2, 8'h20);
        chk("R9 no own", {6'b0, sel_go, disc_stb}, 8'h01);
        wr(4'd11, 8'h08);
        wr(4'd2, 8'h20);
        chk("R9 own only", {6'b0, sel_go, disc_stb}, 8'h01);
        wr(4'd11, 8'h3C);
        wr(4'd8, 8'h01);
        wr(4'd2, 8'h20);
        chk("R9 pctl0", {6'b0, sel_go, disc_stb}, 8'h01);
        wr(4'd4, 8'hFF);

        // R10 transfer
        wr(4'd8, 8'h03);
        psns_in = 8'h8B;
        wr(4'd2, 8'h80);
        chk("R10 start", {7'b0, xfer_active}, 8'h01);
        bus_free = 1'b0;
        wr(4'd2, 8'h00);
        chk("R12 xfer cleared", {6'b0, xfer_active, disc_stb}, 8'h01);
        rd(4'd4, v); chk("R12 disc int", v, 8'h20);
        bus_free = 1'b1;
        wr(4'd4, 8'hFF);
        psns_in = 8'h89;
        wr(4'd2, 8'h80);
        chk("R10 mismatch", {7'b0, xfer_active}, 8'h00);
        rd(4'd4, v); chk("R10 svc", v, 8'h08);
        wr(4'd4, 8'hFF);

        // R11 ACK/REQ strobes
        psns_in = 8'h81;
        wr(4'd2, 8'hE0);
        chk("R11 set", {7'b0, ack_set_stb}, 8'h01);
        chk("R11 in data", ack_data, 8'hC3);
        @(negedge clk);
        chk("R13 ack pulse", {7'b0, ack_set_stb}, 8'h00);
        psns_in = 8'h80;
        wr(4'd2, 8'hE0);
        chk("R11 out data", ack_data, 8'h3C);
        wr(4'd2, 8'hC0);
        chk("R11 clr", {6'b0, ack_clr_stb, ack_set_stb}, 8'h02);

        // R3 disable -> soft reset
        wr(4'd2, 8'h60);
        wr(4'd1, 8'h80);
        chk("R3 disc", {6'b0, disc_stb, atn}, 8'h02);
        chk("R3 disabled", {7'b0, ctl_enabled}, 8'h00);
        rd(4'd2, v); chk("R3 cmd clr", v, 8'h00);
        rd(4'd8, v); chk("R3 pctl clr", v, 8'h00);
        rd(4'd0, v); chk("R3 id kept", v, 8'h08);

        // R6 reset needs control == 0
        wr(4'd1, 8'h01);
        wr(4'd2, 8'h10);
        chk("R6 ctrl nonzero", {7'b0, bus_rst}, 8'h00);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule